// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer

This block guards a processor against a stalled program. A slow periodic tick, nominally one pulse per second and made elsewhere, advances a two-bit state counter. If software does not clear the counter in time, the counter reaches its top state. Half a tick period later the block asserts a system-reset request. That request is held for a fixed number of clock cycles and also returns the watchdog to its power-up state.

Software reaches the block through a small write/read interface with two selectable locations. The control location holds a clear strobe, a sleep-enable flag and the live counter value. The guard location holds an inhibit flag that stops the watchdog. The tick is asynchronous to the system clock, so it is sampled through a synchronizer and its edges are found in the clock domain. Counting does not depend on any low-power state.

Top module: `wdt_guard`

## Requirements
- R1: After `rst`, reading the control location (`rd_sel`=0) returns 0, reading the guard location (`rd_sel`=1) returns 0, and `sys_rst_req_o` and `sleep_en_o` are 0.
- R2: Starting from a cleared counter, successive rising edges of `tick_i` make the counter read 1, 2, 3. The counter occupies bits [1:0] of the control location.
- R3: The first falling edge of `tick_i` while the counter is 3 asserts `sys_rst_req_o`, with a delay shorter than half a tick period.
- R4: `sys_rst_req_o` stays high for exactly `PULSE_LEN` clock cycles. It then returns the counter, the inhibit flag and the sleep-enable flag to 0, and counting resumes on the next rising tick edge.
- R5: Writing the control location (`wr_sel`=0) with bit 3 set makes the counter 0. Writing it with bit 3 clear leaves the counter unchanged. A watchdog cleared on every tick period never requests a reset.
- R6: Bit 3 of the control location always reads 0. Bit 2 holds the sleep-enable value last written there, and that value also drives `sleep_en_o`.
- R7: While bit 0 of the guard location (`wr_sel`=1) is 1, the counter is held at 0 and reads 0, and no reset request is made however many ticks arrive.
- R8: If a clearing write and a rising tick edge fall in the same clock cycle, the counter becomes 0.
- R9: A read returns, one clock cycle after `rd_sel` is presented, the contents of the selected location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset from the other reset sources |
| tick_i | input | 1 | Slow periodic tick, asynchronous to `clk` |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 control, 1 guard |
| wr_data | input | 4 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 guard |
| rd_data | output | 4 | Registered read data |
| sleep_en_o | output | 1 | Stored sleep-enable flag |
| sys_rst_req_o | output | 1 | System-reset request |

## Verification
The bench builds the block with `SYNC_STAGES`=2 and `PULSE_LEN`=4, and uses a tick whose half period is 16 clock cycles. With that scale, a full escalation from a cleared counter to the end of a reset pulse takes about a hundred cycles. Runs with no service, with service on every tick, and with the watchdog inhibited all fit in a short run. Because the synchronizer depth is fixed and small, the bench can place a clearing write in the exact cycle in which a rising tick edge is recognised, which checks the clear-over-advance priority.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 4;
  localparam int CNT_W  = 2;

  localparam int CTRL_CLR_BIT   = 3;
  localparam int CTRL_SLEEP_BIT = 2;
  localparam int GUARD_INH_BIT  = 0;

  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_GUARD = 1'b1
  } wdt_sel_e;
endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_async,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q[0] <= 1'b0;
    else     sh_q[0] <= tick_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sh_q[g] <= 1'b0;
      else     sh_q[g] <= sh_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sh_q[STAGES-1];
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/wdt_state_ctr.sv
module wdt_state_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_int,
  input  logic             inhibit,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst_int || inhibit)      cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (adv && cnt_q != TERM) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o  = cnt_q;
  assign term_o = (cnt_q == TERM);
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic req_o
);
  localparam int PW = $clog2(LEN + 1);
  localparam logic [PW-1:0] LEN_V = PW'(LEN);
  localparam logic [PW-1:0] ONE   = PW'(1);

  logic [PW-1:0] left_q, left_d;
  logic          req_q;

  always_comb begin
    if (fire && left_q == '0) left_d = LEN_V;
    else if (left_q != '0)    left_d = left_q - ONE;
    else                      left_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      req_q  <= 1'b0;
    end else begin
      left_q <= left_d;
      req_q  <= (left_d != '0);
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/wdt_ctl_regs.sv
module wdt_ctl_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_int,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  input  logic [CNT_W-1:0]  cnt,
  output logic              clr_o,
  output logic              inhibit_o,
  output logic              sleep_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              inh_q;
  logic              sleep_q;
  logic [DATA_W-1:0] rd_q;
  logic              wr_ctrl, wr_guard;

  assign wr_ctrl  = wr_en && (wdt_sel_e'(wr_sel) == SEL_CTRL);
  assign wr_guard = wr_en && (wdt_sel_e'(wr_sel) == SEL_GUARD);
  assign clr_o    = wr_ctrl && wr_data[CTRL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst_int) begin
      inh_q   <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      if (wr_guard) inh_q   <= wr_data[GUARD_INH_BIT];
      if (wr_ctrl)  sleep_q <= wr_data[CTRL_SLEEP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (wdt_sel_e'(rd_sel) == SEL_GUARD)
      rd_q <= {{(DATA_W-1){1'b0}}, inh_q};
    else
      rd_q <= {1'b0, sleep_q, cnt};
  end

  assign inhibit_o = inh_q;
  assign sleep_o   = sleep_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              sleep_en_o,
  output logic              sys_rst_req_o
);
  logic             rise_w, fall_w;
  logic [CNT_W-1:0] cnt_w;
  logic             term_w;
  logic             clr_w, inhibit_w;
  logic             req_w;
  logic             rst_int;
  logic             fire_w;

  // the request loops back so the watchdog restarts from its power-up state
  assign rst_int = rst | req_w;
  assign fire_w  = fall_w & term_w & ~inhibit_w;

  wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .tick_async (tick_i),
    .rise_o     (rise_w),
    .fall_o     (fall_w)
  );

  wdt_state_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_int (rst_int),
    .inhibit (inhibit_w),
    .clr     (clr_w),
    .adv     (rise_w),
    .cnt_o   (cnt_w),
    .term_o  (term_w)
  );

  wdt_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire_w),
    .req_o (req_w)
  );

  wdt_ctl_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .rst_int   (rst_int),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .cnt       (cnt_w),
    .clr_o     (clr_w),
    .inhibit_o (inhibit_w),
    .sleep_o   (sleep_en_o),
    .rd_data_o (rd_data)
  );

  assign sys_rst_req_o = req_w;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int PULSE_LEN = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       req,
  input logic [3:0] rd_data,
  input logic [1:0] cnt,
  input logic       rise,
  input logic       fall,
  input logic       term,
  input logic       inhibit,
  input logic       clr
);
  int run_q;

  always_ff @(posedge clk) begin
    if (rst)      run_q <= 0;
    else if (req) run_q <= run_q + 1;
    else          run_q <= 0;
  end

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!req && !inhibit && !clr && rise && cnt != 2'd3) |=> (cnt == $past(cnt) + 2'd1));

  p_fire_r3: assert property (@(posedge clk) disable iff (rst)
    (fall && term && !inhibit && !req) |=> req);

  p_pulse_max_r4: assert property (@(posedge clk) disable iff (rst)
    req |-> (run_q < PULSE_LEN));

  p_pulse_len_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> (run_q == PULSE_LEN));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == 2'd0));

  p_clr_reads0_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_data[3]);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (cnt == 2'd0));

  p_noreq_r7: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !req) |=> !req);
endmodule

bind wdt_guard wdt_guard_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req     (sys_rst_req_o),
  .rd_data (rd_data),
  .cnt     (cnt_w),
  .rise    (rise_w),
  .fall    (fall_w),
  .term    (term_w),
  .inhibit (inhibit_w),
  .clr     (clr_w)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_HALF  = 16;
  localparam int PULSE      = 4;
  localparam int SYNC       = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [3:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [3:0] rd_data;
  logic       sleep_en_o;
  logic       sys_rst_req_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  req_seen = 1'b0;

  // scoreboard queues: expected value, kind (0 read data, 1 reset request), tag
  logic [3:0] exp_q[$];
  bit         kind_q[$];
  string      tag_q[$];

  wdt_guard #(.SYNC_STAGES(SYNC), .PULSE_LEN(PULSE)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick_i),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .rd_sel        (rd_sel),
    .rd_data       (rd_data),
    .sleep_en_o    (sleep_en_o),
    .sys_rst_req_o (sys_rst_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares queued expectations shortly after the falling edge
  always @(negedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      logic [3:0] e;
      bit         k;
      string      t;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      if (k) check(t, int'(sys_rst_req_o), int'(e));
      else   check(t, int'(rd_data), int'(e));
    end
  end

  always @(negedge clk) if (sys_rst_req_o) req_seen = 1'b1;

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic expect_rd(logic sel, logic [3:0] exp, string tag);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    exp_q.push_back(exp); kind_q.push_back(1'b0); tag_q.push_back(tag);
    drain();
  endtask

  task automatic expect_req(logic exp, string tag);
    @(negedge clk);
    exp_q.push_back({3'b0, exp}); kind_q.push_back(1'b1); tag_q.push_back(tag);
    drain();
  endtask

  task automatic wr(logic sel, logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic tick_up();
    @(negedge clk);
    tick_i = 1'b1;
    repeat (TICK_HALF) @(negedge clk);
  endtask

  task automatic tick_down();
    @(negedge clk);
    tick_i = 1'b0;
    repeat (TICK_HALF) @(negedge clk);
  endtask

  // from a cleared counter with sleep flag s: three ticks, then reset pulse
  task automatic escalate(logic s, string tag);
    int dly;
    int len;
    for (int i = 1; i <= 3; i++) begin
      tick_up();
      expect_rd(1'b0, {1'b0, s, 2'(i)}, {tag, " R2 count"});
      if (i < 3) begin
        tick_down();
        expect_req(1'b0, {tag, " R3 no early request"});
      end
    end
    @(negedge clk);
    tick_i = 1'b0;
    dly = 0;
    while (!sys_rst_req_o && dly < 2*TICK_HALF) begin
      @(negedge clk);
      dly++;
    end
    check({tag, " R3 request within half tick"}, int'(dly >= 1 && dly < TICK_HALF), 1);
    len = 0;
    while (sys_rst_req_o && len < 4*PULSE) begin
      @(negedge clk);
      len++;
    end
    check({tag, " R4 pulse length"}, len, PULSE);
    expect_rd(1'b0, 4'h0, {tag, " R4 control cleared after pulse"});
    expect_rd(1'b1, 4'h0, {tag, " R4 guard cleared after pulse"});
    check({tag, " R4 sleep output cleared"}, int'(sleep_en_o), 0);
    repeat (TICK_HALF) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    expect_rd(1'b0, 4'h0, "R1 control after reset");
    expect_rd(1'b1, 4'h0, "R1 guard after reset");
    expect_req(1'b0, "R1 request after reset");
    check("R1 sleep after reset", int'(sleep_en_o), 0);

    // R6 bit 3 reads 0, bit 2 stores sleep flag; R9 read selects location
    wr(1'b0, 4'b1100);
    expect_rd(1'b0, 4'b0100, "R6 clear bit reads 0 with sleep set");
    check("R6 sleep output", int'(sleep_en_o), 1);
    expect_rd(1'b1, 4'h0, "R9 guard read selects guard");

    // R2 R3 R4 unserviced escalation
    escalate(1'b1, "unserviced");

    // R4 counting resumes after the pulse
    tick_up();
    expect_rd(1'b0, 4'h1, "R4 counting resumes");
    tick_down();

    // R5 write without clear bit has no effect
    tick_up();
    expect_rd(1'b0, 4'h2, "R5 precondition count");
    wr(1'b0, 4'b0000);
    expect_rd(1'b0, 4'h2, "R5 write of 0 leaves count");
    wr(1'b0, 4'b1000);
    expect_rd(1'b0, 4'h0, "R5 clear write zeroes count");
    tick_down();

    // R5 serviced every tick: no request
    req_seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick_up();
      wr(1'b0, 4'b1000);
      tick_down();
    end
    check("R5 no request when serviced", int'(req_seen), 0);
    expect_rd(1'b0, 4'h0, "R5 count after service");

    // R8 clear in same cycle as rising edge recognition
    tick_up();
    tick_down();
    expect_rd(1'b0, 4'h1, "R8 precondition count");
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b1000;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    repeat (TICK_HALF - 4) @(negedge clk);
    expect_rd(1'b0, 4'h0, "R8 clear beats advance");
    tick_down();

    // R7 inhibit holds counter at zero
    wr(1'b1, 4'b0001);
    expect_rd(1'b1, 4'h1, "R7 guard reads set");
    req_seen = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick_up();
      expect_rd(1'b0, 4'h0, "R7 count held at 0");
      tick_down();
    end
    check("R7 no request while inhibited", int'(req_seen), 0);
    wr(1'b1, 4'b0000);
    expect_rd(1'b1, 4'h0, "R7 guard reads cleared");

    // escalation again after inhibit released
    escalate(1'b0, "released");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule